// File: doc/BRIEF.md
# Packed-Pixel Window Statistics Engine

This block is a streaming helper for feature matching by normalized correlation. A processor writes a sequence of 32-bit words into the block's input channel. Each data word holds four 8-bit pixels. The block adds them up into window statistics and returns the totals as 32-bit words through an output queue. Software then does the square roots, the division and the final correlation score from those totals.

Every job begins with a command word. The command selects one of two kinds of job and gives the number of pixels in each window. A statistics job yields the pixel sum and then the sum of squared pixels for one window. A product job yields the scalar product of two windows. In a product job, the words of the two windows are interleaved word by word. All four byte lanes of a word are handled in the cycle in which the word is accepted.

The last data word of a window may be only partly used. Lanes past the pixel count are masked off, whatever they contain. Results are never dropped. When the output queue has no room, the input stops accepting words until the results can be stored.

Top module: `pixstat_accel`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: In a command word, bit 31 selects the job (0 = statistics, 1 = product) and bits 15:0 give the pixel count N per window. Bits 30:16 are ignored.
- R3: In data word j of a window, byte lane k (bits 8k+7:8k) carries pixel 4j+k. A statistics job takes ceil(N/4) data words after its command.
- R4: A statistics job returns two words, in this order: the sum of the N pixels, then the sum of their squares.
- R5: A product job takes 2*ceil(N/4) data words, alternating a word of the first window and a word of the second, first window first. It returns one word: the sum over the N pixel pairs of the product of the two pixels.
- R6: In the last word of a window, byte lanes at positions of N or more have no effect on any result.
- R7: With N = 0, no data words follow the command. A statistics job returns 0 and 0, and a product job returns 0.
- R8: The totals are exact for any N up to 65535. In particular, N = 121 with every pixel 255 gives a sum of 30855, a sum of squares of 7868025 and a product of 7868025.
- R9: When the output queue is full, `in_ready` stays 0 until space frees. Every result is delivered once, in the order the jobs were issued.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input word is offered |
| in_ready | output | 1 | The block accepts the offered word |
| in_data | input | 32 | Command word or packed pixel word |
| out_valid | output | 1 | A result word is available |
| out_ready | input | 1 | The consumer takes the result word |
| out_data | output | 32 | Result word |

## Verification
The assertions check some properties on every cycle:
- The result queue is never written while full.
- A held result does not change.
- A pending window always has pixels left.
- A statistics job never goes into the paired-word phase.
- The sum of squares is never below the plain sum.
- The accumulators never wrap.

Other behaviour shows only in the bench's scenarios:
- That the totals are right.
- That byte lanes are taken in order.
- That garbage in masked lanes is ignored.
- That the reserved command bits have no effect.
- That jobs with zero pixels return zeros.
- That no result is lost when the input is stalled behind a full queue.

// File: rtl/pixstat_pkg.sv
package pixstat_pkg;
  // Job sequencer states
  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,  // waiting for a command word
    ST_DATA  = 2'd1,  // consuming pixel words
    ST_PUT_A = 2'd2,  // storing the plain sum
    ST_PUT_B = 2'd3   // storing the squared sum or the product
  } pst_state_e;
endpackage

// File: rtl/pixstat_lane.sv
// One byte lane: masks the pixel and forms its term for the accumulators.
// A single multiplier is shared between squaring and pair products.
module pixstat_lane #(
  parameter int PIX_W = 8
) (
  input  logic               mode_dot,
  input  logic               lane_on,
  input  logic [PIX_W-1:0]   cur_px,
  input  logic [PIX_W-1:0]   hold_px,
  output logic [PIX_W-1:0]   term_a,
  output logic [2*PIX_W-1:0] term_b
);
  localparam int PW2 = 2 * PIX_W;

  logic [PIX_W-1:0] cur_m;
  logic [PIX_W-1:0] other_m;

  always_comb begin
    cur_m   = lane_on ? cur_px : '0;
    other_m = mode_dot ? (lane_on ? hold_px : '0) : cur_m;
    term_a  = mode_dot ? '0 : cur_m;
    term_b  = PW2'(cur_m) * PW2'(other_m);
  end
endmodule

// File: rtl/pixstat_fifo.sv
// Result queue: a storage array with a registered read stage, so the
// array can map to block RAM. Total capacity is DEPTH + 1 words.
module pixstat_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          oq_valid;
  logic [W-1:0]  oq_data;
  logic          push, load;

  assign full     = (cnt == (AW+1)'(DEPTH));
  assign push     = wr_en && !full;
  assign load     = (cnt != '0) && (!oq_valid || rd_ready);
  assign rd_valid = oq_valid;
  assign rd_data  = oq_data;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (load) oq_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      oq_valid <= 1'b0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (load) rd_ptr <= step(rd_ptr);
      if (push && !load)      cnt <= cnt + 1'b1;
      else if (!push && load) cnt <= cnt - 1'b1;
      if (load)               oq_valid <= 1'b1;
      else if (rd_ready)      oq_valid <= 1'b0;
    end
  end

  // R9: the sequencer never writes into a full queue
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);

  // R10: a result that is not taken stays put
  a_r10_hold_result: assert property (@(posedge clk) disable iff (rst)
    (oq_valid && !rd_ready) |=> (oq_valid && $stable(oq_data)));

  // R1: reset empties the output
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> !oq_valid);
endmodule

// File: rtl/pixstat_engine.sv
// Command decode, lane masking, accumulation and result sequencing.
module pixstat_engine
  import pixstat_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  parameter int CNT_W = 16,
  parameter int ACC_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIX_W-1:0] in_data,
  input  logic                   fifo_full,
  output logic                   res_push,
  output logic [ACC_W-1:0]       res_data
);
  localparam int DATA_W   = LANES * PIX_W;
  localparam int MODE_BIT = DATA_W - 1;
  localparam int PW2      = 2 * PIX_W;

  pst_state_e        state;
  logic              mode;     // 1 = product job
  logic              half;     // first word of a pair captured
  logic [CNT_W-1:0]  rem;      // pixels still to come per window
  logic [DATA_W-1:0] hold;
  logic [ACC_W-1:0]  acc_a, acc_b;
  logic [ACC_W-1:0]  sum_a, sum_b;
  logic              take, do_acc, last_grp;

  logic [PIX_W-1:0] ta [LANES];
  logic [PW2-1:0]   tb [LANES];

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    pixstat_lane #(.PIX_W(PIX_W)) lane_i (
      .mode_dot (mode),
      .lane_on  (rem > CNT_W'(gi)),
      .cur_px   (in_data[gi*PIX_W +: PIX_W]),
      .hold_px  (hold[gi*PIX_W +: PIX_W]),
      .term_a   (ta[gi]),
      .term_b   (tb[gi])
    );
  end

  always_comb begin
    sum_a = '0;
    sum_b = '0;
    for (int i = 0; i < LANES; i++) begin
      sum_a = sum_a + ACC_W'(ta[i]);
      sum_b = sum_b + ACC_W'(tb[i]);
    end
  end

  assign in_ready = (state == ST_CMD) || (state == ST_DATA);
  assign take     = in_valid && in_ready;
  assign do_acc   = take && (state == ST_DATA) && !(mode && !half);
  assign last_grp = (rem <= CNT_W'(LANES));
  assign res_push = ((state == ST_PUT_A) || (state == ST_PUT_B)) && !fifo_full;
  assign res_data = (state == ST_PUT_A) ? acc_a : acc_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CMD;
      mode  <= 1'b0;
      half  <= 1'b0;
      rem   <= '0;
      hold  <= '0;
      acc_a <= '0;
      acc_b <= '0;
    end else begin
      unique case (state)
        ST_CMD: if (take) begin
          mode  <= in_data[MODE_BIT];
          rem   <= in_data[CNT_W-1:0];
          half  <= 1'b0;
          acc_a <= '0;
          acc_b <= '0;
          if (in_data[CNT_W-1:0] == '0)
            state <= in_data[MODE_BIT] ? ST_PUT_B : ST_PUT_A;
          else
            state <= ST_DATA;
        end
        ST_DATA: if (take) begin
          if (mode && !half) begin
            hold <= in_data;
            half <= 1'b1;
          end else begin
            acc_a <= acc_a + sum_a;
            acc_b <= acc_b + sum_b;
            half  <= 1'b0;
            if (last_grp) begin
              rem   <= '0;
              state <= mode ? ST_PUT_B : ST_PUT_A;
            end else begin
              rem <= rem - CNT_W'(LANES);
            end
          end
        end
        ST_PUT_A: if (!fifo_full) state <= ST_PUT_B;
        ST_PUT_B: if (!fifo_full) state <= ST_CMD;
        default:  state <= ST_CMD;
      endcase
    end
  end

  // R7: a pending window always has pixels outstanding
  a_r7_pixels_left: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |-> (rem != '0));

  // R5: pairing only happens in product jobs
  a_r5_no_pair_in_stats: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && !mode) |-> !half);

  // R4: integer pixels give a squared sum no smaller than the plain sum
  a_r4_sq_ge_sum: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PUT_A) |-> (acc_b >= acc_a));

  // R8: accumulation never wraps around
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    do_acc |=> ((acc_b >= $past(acc_b)) && (acc_a >= $past(acc_a))));
endmodule

// File: rtl/pixstat_accel.sv
module pixstat_accel #(
  parameter int LANES      = 4,
  parameter int PIX_W      = 8,
  parameter int CNT_W      = 16,
  parameter int ACC_W      = 32,
  parameter int RES_DEPTH  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIX_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [ACC_W-1:0]       out_data
);
  logic             fifo_full;
  logic             res_push;
  logic [ACC_W-1:0] res_data;

  pixstat_engine #(
    .LANES(LANES), .PIX_W(PIX_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
  ) engine_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .fifo_full (fifo_full),
    .res_push  (res_push),
    .res_data  (res_data)
  );

  pixstat_fifo #(.W(ACC_W), .DEPTH(RES_DEPTH)) fifo_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (res_push),
    .wr_data  (res_data),
    .full     (fifo_full),
    .rd_ready (out_ready),
    .rd_valid (out_valid),
    .rd_data  (out_data)
  );
endmodule

// File: tb/pixstat_accel_tb_top.sv
`timescale 1ns/1ps
module pixstat_accel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;
  int stall_cycles = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pixstat_accel dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int pxv(input int seed, input int idx);
    if (seed < 0) return 255;
    return (seed * 29 + idx * 53 + (idx * idx) % 97 + 7) & 255;
  endfunction

  // Word j of a window; lanes past n carry garbage (R6)
  function automatic logic [31:0] mkword(input int seed, input int j, input int n);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = 4 * j + k;
      w[8*k +: 8] = (idx < n) ? 8'(pxv(seed, idx)) : 8'(8'hE7 - 8'(k * 19));
    end
    return w;
  endfunction

  task automatic send_word(input logic [31:0] w);
    logic r;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    forever begin
      r = in_ready;
      if (!r) stall_cycles++;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Issue one job and queue its expected results
  task automatic run_job(input bit dot, input int n, input int s1, input int s2,
                         input logic [14:0] resv, input string tag);
    int a, b, d, nw;
    a = 0; b = 0; d = 0;
    for (int i = 0; i < n; i++) begin
      a += pxv(s1, i);
      b += pxv(s1, i) * pxv(s1, i);
      d += pxv(s1, i) * pxv(s2, i);
    end
    if (!dot) begin
      exp_q.push_back(32'(a)); tag_q.push_back({tag, " sum"});
      exp_q.push_back(32'(b)); tag_q.push_back({tag, " sumsq"});
    end else begin
      exp_q.push_back(32'(d)); tag_q.push_back({tag, " dot"});
    end
    send_word({dot, resv, 16'(n)});
    nw = (n + 3) / 4;
    for (int j = 0; j < nw; j++) begin
      send_word(mkword(s1, j, n));
      if (dot) send_word(mkword(s2, j, n));
    end
  endtask

  // Scoreboard monitor, plus the R10 hold check
  initial begin
    logic        prev_stall = 1'b0;
    logic [31:0] prev_data  = '0;
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        if (prev_stall) begin
          check("R10 valid held", {31'd0, out_valid}, 32'd1);
          check("R10 data held", out_data, prev_data);
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            checks++; bad++;
            $display("FAIL R9: unexpected result got %0d expected none", out_data);
          end else begin
            string t;
            logic [31:0] e;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            check(t, out_data, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);

    run_job(1'b0, 121, 3, 0, 15'h0, "R4 R3 stats window");      // R4 R3
    run_job(1'b0, 121, -1, 0, 15'h0, "R8 stats max");           // R8
    run_job(1'b1, 121, -1, -1, 15'h0, "R8 dot max");            // R8
    run_job(1'b1, 121, 5, 11, 15'h0, "R5 dot window");          // R5
    run_job(1'b0, 5, 7, 0, 15'h0, "R6 stats partial");          // R6
    run_job(1'b1, 7, 9, 2, 15'h0, "R6 R5 dot partial");         // R6 R5
    run_job(1'b0, 1, 4, 0, 15'h0, "R3 lane0 only");             // R3
    run_job(1'b0, 0, 1, 0, 15'h0, "R7 stats empty");            // R7
    run_job(1'b1, 0, 1, 1, 15'h0, "R7 dot empty");              // R7
    run_job(1'b0, 9, 12, 0, 15'h7FFF, "R2 reserved bits");      // R2
    run_job(1'b1, 6, 13, 14, 15'h2A5A, "R2 reserved bits");     // R2
    go_idle();
    repeat (20) @(negedge clk);

    // R9: back-pressure; queue holds 9 words, 12 results are due
    stall_cycles = 0;
    out_ready = 1'b0;
    fork
      begin
        for (int w = 0; w < 6; w++) run_job(1'b0, 8, 20 + w, 0, 15'h0, "R9 stalled");
        go_idle();
      end
      begin
        repeat (200) @(negedge clk);
        out_ready = 1'b1;
      end
    join
    check("R9 input stalled", {31'd0, stall_cycles > 0}, 32'd1);

    for (int t = 0; t < 500 && exp_q.size() != 0; t++) @(negedge clk);
    check("R9 all results delivered", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule